// File: doc/BRIEF.md
# Dual-Pool Physical Register Free List

This block supplies free physical register indices to a register-renaming stage. It keeps two independent first-in-first-out pools, one for integer registers and one for floating-point registers. Both pools share one index space: the floating-point indices start right after the last integer index, so the integer physical count acts as the floating-point base. The rename stage asks each pool for at most one register per cycle. The grant comes back combinationally in the same cycle, and the pool pops at the next clock edge.

Freed registers come back through two kinds of port. The unified release port looks at the index value and sends it to the integer pool, to the floating-point pool, or nowhere. Indices out of range are dropped, and so are the hard-wired zero registers. Each class also has its own release port, and that port pushes whatever it is given with no filtering. Each pool reports an empty flag and an entry count. Two sticky flags report misuse: an allocation from an empty pool, and a push into a pool that is already full, which shows that a register was freed twice.

Top module: `regfree_dual`

## Requirements
- R1: After reset, the integer pool holds, oldest first, the indices from NUM_LOG_INT up to NUM_PHYS_INT-1. The floating-point pool holds, oldest first, the indices from NUM_PHYS_INT+NUM_LOG_FP up to NUM_PHYS_INT+NUM_PHYS_FP-1. Both error flags are low.
- R2: When a pool is not empty, an allocation request raises that class's grant valid in the same cycle, with the oldest entry as the grant index. At the next edge the entry is removed and the count drops by one.
- R3: A unified release of an index below NUM_PHYS_INT is appended to the integer pool. A unified release of an index from NUM_PHYS_INT up to NUM_PHYS_INT+NUM_PHYS_FP-1 is appended to the floating-point pool.
- R4: A unified release of an index at or above NUM_PHYS_INT+NUM_PHYS_FP changes neither pool.
- R5: A unified release of index ZERO_IDX (default 0) is not pushed to the integer pool.
- R6: When FP_ZERO_EN is 1 (the default), a unified release of index ZERO_IDX+NUM_PHYS_INT (default 16) is not pushed to the floating-point pool.
- R7: The class-specific release ports append their index to their own pool with no range check and no zero-register check.
- R8: Each class's empty output is high exactly when its count output is zero. The count equals the number of entries held.
- R9: An allocation request to an empty pool gives no grant and leaves the pool unchanged. It sets alloc_err, which stays high until reset.
- R10: A push into a pool that already holds its physical count of entries is dropped. It sets overflow_err, which stays high until reset.
- R11: When an allocation and a release hit the same pool in one cycle, both take effect, so a non-empty pool keeps its count. If the pool was empty, no grant is given, and the index released in that cycle is not granted until a later cycle.
- R12: When the unified port and the class port push to the same pool in one cycle, both are accepted. The unified index is queued ahead of the class-port index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_alloc_req | input | 1 | Request one integer register |
| int_alloc_vld | output | 1 | Integer grant valid |
| int_alloc_idx | output | IDX_W | Granted integer index |
| int_empty | output | 1 | Integer pool empty |
| int_count | output | $clog2(NUM_PHYS_INT+1) | Integer pool occupancy |
| fp_alloc_req | input | 1 | Request one floating-point register |
| fp_alloc_vld | output | 1 | Floating-point grant valid |
| fp_alloc_idx | output | IDX_W | Granted floating-point index |
| fp_empty | output | 1 | Floating-point pool empty |
| fp_count | output | $clog2(NUM_PHYS_FP+1) | Floating-point pool occupancy |
| rel_vld | input | 1 | Unified release valid |
| rel_idx | input | IDX_W | Unified release index, routed by value |
| int_rel_vld | input | 1 | Integer-port release valid |
| int_rel_idx | input | IDX_W | Index pushed to the integer pool unfiltered |
| fp_rel_vld | input | 1 | Floating-point-port release valid |
| fp_rel_idx | input | IDX_W | Index pushed to the floating-point pool unfiltered |
| alloc_err | output | 1 | Sticky: allocation from an empty pool |
| overflow_err | output | 1 | Sticky: push into a full pool dropped |

## Verification
The bench targets the routing boundaries: the last integer index, the first floating-point index, the total count exactly, an index past the total, and both zero registers. A design with an off-by-one in its range compare would misfile or keep one of these indices. It empties a pool and then allocates and releases in the same cycle. A design that bypasses the pushed index would grant it early, and one that let the push or the pop win alone would get the count wrong. It fills a pool past its capacity and pushes through both release ports in one cycle, which catches a lost second write, a wrapped pointer that overwrites live entries, and a wrong FIFO order.

// File: rtl/regfree_pkg.sv
package regfree_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_INT  = 2'd1,
    RT_FP   = 2'd2
  } rel_route_e;
endpackage

// File: rtl/regfree_router.sv
module regfree_router
  import regfree_pkg::*;
#(
  parameter int NUM_PHYS_INT = 16,
  parameter int NUM_PHYS_FP  = 16,
  parameter int ZERO_IDX     = 0,
  parameter bit FP_ZERO_EN   = 1'b1,
  parameter int IDX_W        = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_vld,
  input  logic [IDX_W-1:0] rel_idx,
  output logic             to_int,
  output logic             to_fp
);
  localparam int TOTAL   = NUM_PHYS_INT + NUM_PHYS_FP;
  localparam int FP_ZERO = ZERO_IDX + NUM_PHYS_INT;

  rel_route_e route;

  always_comb begin
    route = RT_NONE;
    if (rel_vld) begin
      if (int'(rel_idx) < NUM_PHYS_INT) begin
        if (int'(rel_idx) != ZERO_IDX) route = RT_INT;
      end else if (int'(rel_idx) < TOTAL) begin
        if (!(FP_ZERO_EN && int'(rel_idx) == FP_ZERO)) route = RT_FP;
      end
    end
  end

  assign to_int = (route == RT_INT);
  assign to_fp  = (route == RT_FP);

  AST_DROP_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld && int'(rel_idx) >= TOTAL) |-> (!to_int && !to_fp)); // R4
  AST_INT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld && int'(rel_idx) == ZERO_IDX) |-> !to_int); // R5
  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !(to_int && to_fp)); // R3
endmodule

// File: rtl/regfree_pool.sv
module regfree_pool #(
  parameter int DEPTH = 16,
  parameter int NLOG  = 8,
  parameter int BASE  = 0,
  parameter int IDX_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_req,
  output logic                       alloc_vld,
  output logic [IDX_W-1:0]           alloc_idx,
  input  logic                       push0_vld,
  input  logic [IDX_W-1:0]           push0_idx,
  input  logic                       push1_vld,
  input  logic [IDX_W-1:0]           push1_idx,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       alloc_err,
  output logic                       ovf_err
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int INIT  = DEPTH - NLOG;

  logic [IDX_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d, wr1_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_d, avail;
  logic             aerr_q, aerr_d, oerr_q, oerr_d;
  logic             pop, acc0, acc1;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop     = alloc_req && (cnt_q != '0);
    avail   = cnt_q - CNT_W'(pop);
    acc0    = push0_vld && (avail < CNT_W'(DEPTH));
    acc1    = push1_vld && ((avail + CNT_W'(acc0)) < CNT_W'(DEPTH));
    wr1_ptr = acc0 ? ptr_inc(tail_q) : tail_q;
    tail_d  = acc1 ? ptr_inc(wr1_ptr) : wr1_ptr;
    head_d  = pop ? ptr_inc(head_q) : head_q;
    cnt_d   = avail + CNT_W'(acc0) + CNT_W'(acc1);
    aerr_d  = aerr_q || (alloc_req && cnt_q == '0);
    oerr_d  = oerr_q || (push0_vld && !acc0) || (push1_vld && !acc1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= PTR_W'(INIT % DEPTH);
      cnt_q  <= CNT_W'(INIT);
      aerr_q <= 1'b0;
      oerr_q <= 1'b0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      aerr_q <= aerr_d;
      oerr_q <= oerr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i < INIT) ? IDX_W'(BASE + NLOG + i) : '0;
    end else begin
      if (acc0) mem_q[tail_q]  <= push0_idx;
      if (acc1) mem_q[wr1_ptr] <= push1_idx;
    end
  end

  assign alloc_vld = pop;
  assign alloc_idx = mem_q[head_q];
  assign empty     = (cnt_q == '0);
  assign count     = cnt_q;
  assign alloc_err = aerr_q;
  assign ovf_err   = oerr_q;

  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && cnt_q != '0 && !push0_vld && !push1_vld)
      |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && cnt_q == '0 && !push0_vld && !push1_vld) |=> (cnt_q == '0)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |=> alloc_err); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err); // R10
  AST_SWAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && cnt_q != '0 && push0_vld && !push1_vld) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/regfree_dual.sv
module regfree_dual #(
  parameter int NUM_LOG_INT  = 8,
  parameter int NUM_PHYS_INT = 16,
  parameter int NUM_LOG_FP   = 8,
  parameter int NUM_PHYS_FP  = 16,
  parameter int ZERO_IDX     = 0,
  parameter bit FP_ZERO_EN   = 1'b1,
  localparam int IDX_W = $clog2(NUM_PHYS_INT + NUM_PHYS_FP + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              int_alloc_req,
  output logic                              int_alloc_vld,
  output logic [IDX_W-1:0]                  int_alloc_idx,
  output logic                              int_empty,
  output logic [$clog2(NUM_PHYS_INT+1)-1:0] int_count,
  input  logic                              fp_alloc_req,
  output logic                              fp_alloc_vld,
  output logic [IDX_W-1:0]                  fp_alloc_idx,
  output logic                              fp_empty,
  output logic [$clog2(NUM_PHYS_FP+1)-1:0]  fp_count,
  input  logic                              rel_vld,
  input  logic [IDX_W-1:0]                  rel_idx,
  input  logic                              int_rel_vld,
  input  logic [IDX_W-1:0]                  int_rel_idx,
  input  logic                              fp_rel_vld,
  input  logic [IDX_W-1:0]                  fp_rel_idx,
  output logic                              alloc_err,
  output logic                              overflow_err
);
  logic to_int, to_fp;
  logic int_aerr, fp_aerr, int_oerr, fp_oerr;

  regfree_router #(
    .NUM_PHYS_INT(NUM_PHYS_INT), .NUM_PHYS_FP(NUM_PHYS_FP),
    .ZERO_IDX(ZERO_IDX), .FP_ZERO_EN(FP_ZERO_EN), .IDX_W(IDX_W)
  ) u_router (
    .clk(clk), .rst_n(rst_n), .rel_vld(rel_vld), .rel_idx(rel_idx),
    .to_int(to_int), .to_fp(to_fp)
  );

  regfree_pool #(
    .DEPTH(NUM_PHYS_INT), .NLOG(NUM_LOG_INT), .BASE(0), .IDX_W(IDX_W)
  ) u_int_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(int_alloc_req), .alloc_vld(int_alloc_vld), .alloc_idx(int_alloc_idx),
    .push0_vld(to_int), .push0_idx(rel_idx),
    .push1_vld(int_rel_vld), .push1_idx(int_rel_idx),
    .empty(int_empty), .count(int_count),
    .alloc_err(int_aerr), .ovf_err(int_oerr)
  );

  regfree_pool #(
    .DEPTH(NUM_PHYS_FP), .NLOG(NUM_LOG_FP), .BASE(NUM_PHYS_INT), .IDX_W(IDX_W)
  ) u_fp_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(fp_alloc_req), .alloc_vld(fp_alloc_vld), .alloc_idx(fp_alloc_idx),
    .push0_vld(to_fp), .push0_idx(rel_idx),
    .push1_vld(fp_rel_vld), .push1_idx(fp_rel_idx),
    .empty(fp_empty), .count(fp_count),
    .alloc_err(fp_aerr), .ovf_err(fp_oerr)
  );

  assign alloc_err    = int_aerr | fp_aerr;
  assign overflow_err = int_oerr | fp_oerr;

  AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (int_empty == (int_count == '0)) && (fp_empty == (fp_count == '0))); // R8
  AST_EMPTY_NOGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (int_empty |-> !int_alloc_vld)); // R11
endmodule

// File: tb/regfree_dual_tb.sv
module regfree_dual_tb;
  localparam int NPI = 16, NPF = 16, NLI = 8, NLF = 8, TOT = NPI + NPF;
  localparam int IW = $clog2(TOT + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic int_alloc_req = 0, fp_alloc_req = 0, rel_vld = 0, int_rel_vld = 0, fp_rel_vld = 0;
  logic [IW-1:0] rel_idx = '0, int_rel_idx = '0, fp_rel_idx = '0;
  logic int_alloc_vld, fp_alloc_vld, int_empty, fp_empty, alloc_err, overflow_err;
  logic [IW-1:0] int_alloc_idx, fp_alloc_idx;
  logic [$clog2(NPI+1)-1:0] int_count;
  logic [$clog2(NPF+1)-1:0] fp_count;

  int total = 0, fails = 0;
  bit done = 0;
  int qi[$], qf[$];
  bit m_ae, m_oe;

  always #4 clk = ~clk;

  regfree_dual u_dut (.*);

  // routing table: unified index, expected int delta, expected fp delta, req tag
  localparam int NV = 10;
  localparam int TV_IDX [NV] = '{3, 15, 16, 17, 0, 31, 32, 40, 20, 63};
  localparam int TV_DI  [NV] = '{1, 1, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam int TV_DF  [NV] = '{0, 0, 0, 1, 0, 1, 0, 0, 1, 0};
  localparam int TV_REQ [NV] = '{3, 3, 6, 3, 5, 3, 4, 4, 3, 4};

  function automatic string rtag(int n);
    case (n)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic mpush(ref int q[$], input int v);
    if (q.size() < 16) q.push_back(v); else m_oe = 1;
  endtask

  task automatic model_reset();
    qi.delete(); qf.delete(); m_ae = 0; m_oe = 0;
    for (int i = NLI; i < NPI; i++) qi.push_back(i);
    for (int i = NPI + NLF; i < TOT; i++) qf.push_back(i);
  endtask

  task automatic check_state(string tag);
    check({tag, " int_count"}, int'(int_count), qi.size());
    check({tag, " fp_count"}, int'(fp_count), qf.size());
    check({tag, " int_empty"}, int'(int_empty), int'(qi.size() == 0));
    check({tag, " fp_empty"}, int'(fp_empty), int'(qf.size() == 0));
    check({tag, " alloc_err"}, int'(alloc_err), int'(m_ae));
    check({tag, " overflow_err"}, int'(overflow_err), int'(m_oe));
  endtask

  task automatic cyc(bit ir, bit fr, bit uv, int ui, bit iv, int ii, bit fv, int fi,
                     string tag);
    bit ei, ef;
    @(negedge clk);
    int_alloc_req = ir; fp_alloc_req = fr;
    rel_vld = uv; rel_idx = IW'(ui);
    int_rel_vld = iv; int_rel_idx = IW'(ii);
    fp_rel_vld = fv; fp_rel_idx = IW'(fi);
    #2;
    ei = ir && qi.size() > 0;
    ef = fr && qf.size() > 0;
    check({tag, " int_alloc_vld"}, int'(int_alloc_vld), int'(ei));
    if (ei) check({tag, " int_alloc_idx"}, int'(int_alloc_idx), qi[0]);
    check({tag, " fp_alloc_vld"}, int'(fp_alloc_vld), int'(ef));
    if (ef) check({tag, " fp_alloc_idx"}, int'(fp_alloc_idx), qf[0]);
    @(posedge clk); #1;
    int_alloc_req = 0; fp_alloc_req = 0; rel_vld = 0; int_rel_vld = 0; fp_rel_vld = 0;
    if (ir && !ei) m_ae = 1;
    if (fr && !ef) m_ae = 1;
    if (ei) void'(qi.pop_front());
    if (ef) void'(qf.pop_front());
    if (uv) begin
      if (ui < NPI) begin
        if (ui != 0) mpush(qi, ui);
      end else if (ui < TOT) begin
        if (ui != NPI) mpush(qf, ui);
      end
    end
    if (iv) mpush(qi, ii);
    if (fv) mpush(qf, fi);
    check_state(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int ci, cf;
    do_reset();
    check_state("R1 reset");
    check("R8 reset int_count", int'(int_count), NPI - NLI);

    // routing table walk
    for (int k = 0; k < NV; k++) begin
      ci = int'(int_count); cf = int'(fp_count);
      cyc(0, 0, 1, TV_IDX[k], 0, 0, 0, 0, rtag(TV_REQ[k]));
      check({rtag(TV_REQ[k]), " int delta"}, int'(int_count) - ci, TV_DI[k]);
      check({rtag(TV_REQ[k]), " fp delta"}, int'(fp_count) - cf, TV_DF[k]);
    end

    // drain integer pool in FIFO order (reset entries, then routed ones)
    check("R1 int head", int'(int_alloc_idx), NLI);
    while (qi.size() > 0) cyc(1, 0, 0, 0, 0, 0, 0, 0, "R2");
    check("R8 int empty", int'(int_empty), 1);

    // allocate from empty pool
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R9");
    check("R9 alloc_err set", int'(alloc_err), 1);

    // same-cycle alloc + release on empty then on non-empty pool
    cyc(1, 0, 0, 0, 1, 5, 0, 0, "R11 empty");
    cyc(1, 0, 0, 0, 1, 6, 0, 0, "R11 swap");
    check("R11 count held", int'(int_count), 1);

    // class ports push unfiltered
    cyc(0, 0, 0, 0, 1, 0, 1, NPI, "R7");
    cyc(1, 1, 0, 0, 0, 0, 0, 0, "R7 alloc");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R7 zero granted");

    // both ports into one pool in one cycle
    cyc(0, 0, 1, 9, 1, 10, 0, 0, "R12");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R12 first");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R12 second");
    cyc(0, 1, 1, 22, 0, 0, 1, 23, "R12 fp");
    check("R9 err sticky", int'(alloc_err), 1);

    // fill fp pool, then overflow via both ports
    while (qf.size() < NPF) cyc(0, 0, 0, 0, 0, 0, 1, 18, "R10 fill");
    cyc(0, 0, 1, 19, 0, 0, 1, 25, "R10");
    check("R10 overflow_err", int'(overflow_err), 1);
    check("R10 fp_count", int'(fp_count), NPF);
    while (qf.size() > 0) cyc(0, 1, 0, 0, 0, 0, 0, 0, "R10 drain");

    do_reset();
    check_state("R9 reset clears");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule